// File: doc/BRIEF.md
# Real-Time Clock Alarm Match and Interrupt Pin Unit

This unit sits beside the timekeeping counters of a real-time clock. Once per second, on a tick from the counter chain, it compares the live time against two alarm register sets. The first alarm set covers seconds, minutes, hours and day or date. The second alarm set covers minutes, hours and day or date, and always requires the seconds to read 00. Each alarm byte carries a mask bit that removes its field from the compare. The day/date byte also carries a select bit that picks day of week or date of month as the compare target.

A match sets a sticky flag. Software can only clear a flag by writing 0 to it. An oscillator-stop flag works the same way. It is set out of reset and whenever software turns the oscillator off. The block holds its own control register, which picks between two pin modes. In the first mode the pin shows a square wave at one of four rates, taken from a divider advanced by a half-period oscillator enable. In the second mode the pin is pulled low while any enabled flag is set. While the chip runs from backup power, the pin is released to high impedance unless a keep-alive bit allows it to keep working.

The pin is modelled as an open-drain driver: a drive-low enable plus a high-impedance indication.

Top module: `rtc_alarm_irq`

## Requirements
- R1: After reset, `ctrl_q` reads 7'h03 (rate 3, square-wave mode, both enables off, keep-alive off, oscillator on) and `stat_q` reads 3'b100 (oscillator-stop flag set, both alarm flags clear).
- R2: Alarm set 1 is compared only in a cycle where `sec_tick` is 1. Bit 7 of each alarm byte is a mask. When the mask is 1 the field counts as matched. When it is 0, bits 6:0 must equal the live BCD field. On a full match, `stat_q[0]` is 1 from the cycle after the tick. So masks 1111 fire every second, and clearing the masks in the order seconds, minutes, hours adds each field in turn.
- R3: In a day/date alarm byte, bit 6 picks the target. With bit 6 at 0, bits 5:0 are compared with the date. With bit 6 at 1, they are compared with the 3-bit day of week, zero-extended.
- R4: Alarm set 2 has no seconds byte and matches only when the live seconds read 00. Its minutes, hours and day/date bytes follow the R2 and R3 rules, and a match sets `stat_q[1]`.
- R5: No alarm flag is set in a cycle without `sec_tick`, even when the time matches.
- R6: A status write with `stat_we` clears each bit of `stat_q` whose `stat_wdata` bit is 0. A 1 leaves that bit unchanged. If a match or an oscillator-stop event occurs in the same cycle, the set wins.
- R7: Writing control bit 6 (oscillator off) from 0 to 1 sets `stat_q[2]`. While bit 6 is 1, the square-wave divider does not advance.
- R8: With control bit 2 at 1 (interrupt mode), `pin_drive_low` is 1 exactly when (`stat_q[0]` and control bit 3) or (`stat_q[1]` and control bit 4).
- R9: With control bit 2 at 0, the pin shows a square wave picked by control bits 1:0. The divider counts `osc_half_en` pulses, which arrive 65,536 times per second, and is zeroed by reset. Rate 0 gives 1 Hz, with a half period of 32768 pulses. Rate 1 gives 4.096 kHz (half period 8), rate 2 gives 8.192 kHz (half period 4), and rate 3 gives 32.768 kHz (half period 1). The pin is driven low during the first half period after the divider is zeroed.
- R10: When `on_backup` is 1 and control bit 5 (keep-alive) is 0, `pin_hiz` is 1 and `pin_drive_low` is 0. When control bit 5 is 1, the pin keeps operating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_half_en | input | 1 | One pulse per oscillator half period |
| sec_tick | input | 1 | One-cycle pulse per second from the counter chain |
| t_sec | input | 7 | Live seconds, BCD |
| t_min | input | 7 | Live minutes, BCD |
| t_hour | input | 7 | Live hours byte, bits 6:0 |
| t_day | input | 3 | Live day of week |
| t_date | input | 6 | Live date of month, BCD |
| al1_sec | input | 8 | Alarm 1 seconds: mask bit 7, value bits 6:0 |
| al1_min | input | 8 | Alarm 1 minutes: mask bit 7, value bits 6:0 |
| al1_hour | input | 8 | Alarm 1 hours: mask bit 7, value bits 6:0 |
| al1_dd | input | 8 | Alarm 1 day/date: mask bit 7, select bit 6, value bits 5:0 |
| al2_min | input | 8 | Alarm 2 minutes |
| al2_hour | input | 8 | Alarm 2 hours |
| al2_dd | input | 8 | Alarm 2 day/date |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 7 | Control write data |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 3 | Status write data, 0 clears a bit |
| on_backup | input | 1 | Chip is running from the backup supply |
| ctrl_q | output | 7 | Control register value |
| stat_q | output | 3 | Flags: bit 2 oscillator stop, bit 1 alarm 2, bit 0 alarm 1 |
| pin_drive_low | output | 1 | Pull the output pin low |
| pin_hiz | output | 1 | Output pin released to high impedance |

## Verification
A wrong compare or mask decode shows up on `stat_q` one cycle after the tick that should or should not have fired. The bench checks this both with the time one count away from the alarm and exactly on it. A flag that a software write sets or fails to clear shows on `stat_q` in the cycle after the write. In interrupt mode the same fault shows on the pin at once. A wrong divider tap or a divider that keeps running while stopped shows as a pin level on the wrong side of a half-period boundary. That boundary is sampled one pulse before and one pulse after it.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

    localparam int NUM_ALARMS = 2;
    localparam int FIELDS     = 4;   // sec, min, hour, day/date
    localparam int AL_W       = 8;
    localparam int CTRL_W     = 7;
    localparam int STAT_W     = NUM_ALARMS + 1;
    localparam int DIV_W      = 16;

    // divider taps for each rate code
    localparam int TAP_SLOW   = DIV_W - 1;
    localparam int TAP_R1     = 3;
    localparam int TAP_R2     = 2;
    localparam int TAP_FAST   = 0;

    typedef struct packed {
        logic       osc_off;
        logic       keep_bkp;
        logic       en2;
        logic       en1;
        logic       irq_mode;
        logic [1:0] rate;
    } ctrl_t;

    typedef struct packed {
        logic                  osf;
        logic [NUM_ALARMS-1:0] flag;
    } stat_t;

    localparam ctrl_t CTRL_RST = '{osc_off: 1'b0, keep_bkp: 1'b0, en2: 1'b0,
                                   en1: 1'b0, irq_mode: 1'b0, rate: 2'b11};
    localparam stat_t STAT_RST = '{osf: 1'b1, flag: '0};

    typedef logic [FIELDS-1:0][AL_W-1:0] alarm_set_t;

    function automatic logic field_ok(input logic [AL_W-1:0] al,
                                      input logic [6:0] live);
        return al[7] | (al[6:0] == live);
    endfunction

    function automatic logic daydate_ok(input logic [AL_W-1:0] al,
                                        input logic [2:0] day,
                                        input logic [5:0] date);
        logic eq;
        eq = al[6] ? (al[5:0] == {3'b000, day}) : (al[5:0] == date);
        return al[7] | eq;
    endfunction

endpackage

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic       tick,
    input  logic [6:0] live_sec,
    input  logic [6:0] live_min,
    input  logic [6:0] live_hour,
    input  logic [2:0] live_day,
    input  logic [5:0] live_date,
    input  alarm_set_t al,
    output logic       hit
);
    logic sec_ok, min_ok, hour_ok, dd_ok;

    always_comb begin
        sec_ok  = field_ok(al[0], live_sec);
        min_ok  = field_ok(al[1], live_min);
        hour_ok = field_ok(al[2], live_hour);
        dd_ok   = daydate_ok(al[3], live_day, live_date);
        hit     = tick & sec_ok & min_ok & hour_ok & dd_ok;
    end
endmodule

// File: rtl/alarm_regs.sv
module alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ctrl_we,
    input  logic [CTRL_W-1:0]     ctrl_wdata,
    input  logic                  stat_we,
    input  logic [STAT_W-1:0]     stat_wdata,
    input  logic [NUM_ALARMS-1:0] set,
    output ctrl_t                 ctrl,
    output stat_t                 stat
);
    logic  osc_evt;
    stat_t stat_nx;

    always_comb begin
        osc_evt = ctrl_we & ctrl_wdata[CTRL_W-1] & ~ctrl.osc_off;
        stat_nx = stat;
        if (stat_we) stat_nx = stat_t'(stat & stat_wdata);
        stat_nx.flag = stat_nx.flag | set;
        stat_nx.osf  = stat_nx.osf | osc_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= CTRL_RST;
            stat <= STAT_RST;
        end else begin
            if (ctrl_we) ctrl <= ctrl_t'(ctrl_wdata);
            stat <= stat_nx;
        end
    end

    // R7: turning the oscillator off raises the stop flag
    a_r7_osf_on_stop: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we && ctrl_wdata[CTRL_W-1] && !ctrl.osc_off) |=> stat.osf);

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_flag_chk
        // R6: a zero write with no set in that cycle clears the flag
        a_r6_zero_clears: assert property (@(posedge clk) disable iff (rst)
            (stat_we && !stat_wdata[i] && !set[i]) |=> !stat.flag[i]);
        // R6: a flag only rises through a match
        a_r6_rise_needs_set: assert property (@(posedge clk) disable iff (rst)
            $rose(stat.flag[i]) |-> $past(set[i]));
    end
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       half_en,
    input  logic       run,
    input  logic [1:0] rate,
    output logic       level
);
    logic [DIV_W-1:0] div;

    always_ff @(posedge clk) begin
        if (rst)                div <= '0;
        else if (half_en && run) div <= div + 1'b1;
    end

    always_comb begin
        unique case (rate)
            2'd0:    level = div[TAP_SLOW];
            2'd1:    level = div[TAP_R1];
            2'd2:    level = div[TAP_R2];
            default: level = div[TAP_FAST];
        endcase
    end

    // R7: a stopped oscillator freezes the divider
    a_r7_div_frozen: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(div));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_half_en,
    input  logic              sec_tick,
    input  logic [6:0]        t_sec,
    input  logic [6:0]        t_min,
    input  logic [6:0]        t_hour,
    input  logic [2:0]        t_day,
    input  logic [5:0]        t_date,
    input  logic [7:0]        al1_sec,
    input  logic [7:0]        al1_min,
    input  logic [7:0]        al1_hour,
    input  logic [7:0]        al1_dd,
    input  logic [7:0]        al2_min,
    input  logic [7:0]        al2_hour,
    input  logic [7:0]        al2_dd,
    input  logic              ctrl_we,
    input  logic [6:0]        ctrl_wdata,
    input  logic              stat_we,
    input  logic [2:0]        stat_wdata,
    input  logic              on_backup,
    output logic [6:0]        ctrl_q,
    output logic [2:0]        stat_q,
    output logic              pin_drive_low,
    output logic              pin_hiz
);
    alarm_set_t            al_sets [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] hits;
    ctrl_t                 ctrl;
    stat_t                 stat;
    logic                  wave;
    logic                  irq_act;

    // alarm 2 has no seconds byte: an unmasked 00 forces second zero
    assign al_sets[0] = {al1_dd, al1_hour, al1_min, al1_sec};
    assign al_sets[1] = {al2_dd, al2_hour, al2_min, 8'h00};

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
        alarm_cmp u_cmp (
            .tick      (sec_tick),
            .live_sec  (t_sec),
            .live_min  (t_min),
            .live_hour (t_hour),
            .live_day  (t_day),
            .live_date (t_date),
            .al        (al_sets[i]),
            .hit       (hits[i])
        );
    end

    alarm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .stat_we    (stat_we),
        .stat_wdata (stat_wdata),
        .set        (hits),
        .ctrl       (ctrl),
        .stat       (stat)
    );

    sqw_gen u_sqw (
        .clk     (clk),
        .rst     (rst),
        .half_en (osc_half_en),
        .run     (~ctrl.osc_off),
        .rate    (ctrl.rate),
        .level   (wave)
    );

    always_comb begin
        irq_act       = |(stat.flag & {ctrl.en2, ctrl.en1});
        pin_hiz       = on_backup & ~ctrl.keep_bkp;
        pin_drive_low = ~pin_hiz & (ctrl.irq_mode ? irq_act : ~wave);
        ctrl_q        = ctrl;
        stat_q        = stat;
    end

    // R5: flags rise only after a seconds tick
    a_r5_flag1_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[0]) |-> $past(sec_tick));
    a_r5_flag2_after_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[1]) |-> $past(sec_tick));
    // R8: in interrupt mode no enabled flag means a released pin
    a_r8_irq_idle: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[2] && !(stat_q[0] && ctrl_q[3]) && !(stat_q[1] && ctrl_q[4]))
            |-> !pin_drive_low);
    // R10: a released pin never drives
    a_r10_hiz_quiet: assert property (@(posedge clk) disable iff (rst)
        pin_hiz |-> !pin_drive_low);
endmodule

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic osc_half_en = 0, sec_tick = 0;
    logic [6:0] t_sec = 0, t_min = 0, t_hour = 0;
    logic [2:0] t_day = 0;
    logic [5:0] t_date = 0;
    logic [7:0] al1_sec = 8'h59, al1_min = 8'h59, al1_hour = 8'h23, al1_dd = 8'h31;
    logic [7:0] al2_min = 8'h59, al2_hour = 8'h23, al2_dd = 8'h31;
    logic ctrl_we = 0, stat_we = 0, on_backup = 0;
    logic [6:0] ctrl_wdata = 0;
    logic [2:0] stat_wdata = 0;
    logic [6:0] ctrl_q;
    logic [2:0] stat_q;
    logic pin_drive_low, pin_hiz;

    always #2 clk = ~clk;

    rtc_alarm_irq u0 (.*);

    typedef struct {
        int         kind;   // 0 stat, 1 ctrl, 2 drive_low, 3 hiz
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb [$];
    int checks = 0, errors = 0;
    bit done = 0;

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic expect_val(input int kind, input logic [7:0] e, input string tag);
        item_t it;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = {5'b0, stat_q};
                1: act = {1'b0, ctrl_q};
                2: act = {7'b0, pin_drive_low};
                default: act = {7'b0, pin_hiz};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s: got %0h expected %0h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr_ctrl(input logic [6:0] v);
        ctrl_we = 1; ctrl_wdata = v; step(); ctrl_we = 0;
    endtask

    task automatic wr_stat(input logic [2:0] v);
        stat_we = 1; stat_wdata = v; step(); stat_we = 0;
    endtask

    task automatic tick();
        sec_tick = 1; step(); sec_tick = 0;
    endtask

    task automatic set_time(input logic [6:0] s, m, h, input logic [2:0] d,
                            input logic [5:0] dt);
        t_sec = s; t_min = m; t_hour = h; t_day = d; t_date = dt;
    endtask

    task automatic wave_test(input logic [1:0] r, input int half, input string tag);
        rst = 1; step(); rst = 0;
        wr_ctrl({5'b0, r});
        osc_half_en = 1;
        repeat (half - 1) step();
        expect_val(2, 8'd1, {tag, " before half"});
        step();
        expect_val(2, 8'd0, {tag, " at half"});
        if (half < 100) begin
            repeat (half) step();
            expect_val(2, 8'd1, {tag, " full period"});
        end
        osc_half_en = 0;
        step();
    endtask

    initial begin
        repeat (2) step();
        rst = 0;
        step();
        expect_val(1, 8'h03, "R1 ctrl reset");
        expect_val(0, 8'h04, "R1 stat reset");
        expect_val(3, 8'h00, "R1 hiz reset");

        wr_stat(3'b011);
        expect_val(0, 8'h00, "R6 zero clears osf");
        wr_stat(3'b111);
        expect_val(0, 8'h00, "R6 one leaves clear");

        // R2 every second
        al1_sec = 8'h80; al1_min = 8'h80; al1_hour = 8'h80; al1_dd = 8'h80;
        set_time(7'h17, 7'h42, 7'h05, 3'd2, 6'h09);
        tick();
        expect_val(0, 8'h01, "R2 masks 1111 fire");
        wr_stat(3'b110);
        expect_val(0, 8'h00, "R6 clear flag1");
        // R2 seconds match
        al1_sec = 8'h25;
        set_time(7'h24, 7'h42, 7'h05, 3'd2, 6'h09); tick();
        expect_val(0, 8'h00, "R2 sec mismatch");
        t_sec = 7'h25; tick();
        expect_val(0, 8'h01, "R2 sec match");
        wr_stat(3'b000);
        // minutes + seconds
        al1_min = 8'h10; t_min = 7'h11; tick();
        expect_val(0, 8'h00, "R2 min mismatch");
        t_min = 7'h10; tick();
        expect_val(0, 8'h01, "R2 min+sec match");
        wr_stat(3'b000);
        // hours
        al1_hour = 8'h08; t_hour = 7'h09; tick();
        expect_val(0, 8'h00, "R2 hour mismatch");
        t_hour = 7'h08; tick();
        expect_val(0, 8'h01, "R2 hour match");
        wr_stat(3'b000);
        // R3 date
        al1_dd = 8'h15; t_date = 6'h15; t_day = 3'd3; tick();
        expect_val(0, 8'h01, "R3 date match");
        wr_stat(3'b000);
        t_date = 6'h14; tick();
        expect_val(0, 8'h00, "R3 date mismatch");
        al1_dd = 8'h43; tick();
        expect_val(0, 8'h01, "R3 day match");
        wr_stat(3'b000);
        t_day = 3'd4; tick();
        expect_val(0, 8'h00, "R3 day mismatch");

        // R5 no tick
        t_day = 3'd3;
        repeat (3) step();
        expect_val(0, 8'h00, "R5 match without tick");

        // R4 alarm 2
        al1_sec = 8'h59; al1_dd = 8'h31;
        al2_min = 8'h80; al2_hour = 8'h80; al2_dd = 8'h80;
        set_time(7'h01, 7'h30, 7'h12, 3'd1, 6'h01); tick();
        expect_val(0, 8'h00, "R4 nonzero seconds");
        t_sec = 7'h00; tick();
        expect_val(0, 8'h02, "R4 per minute");
        wr_stat(3'b000);
        al2_min = 8'h30; t_min = 7'h31; tick();
        expect_val(0, 8'h00, "R4 min mismatch");
        t_min = 7'h30; tick();
        expect_val(0, 8'h02, "R4 min match");

        // R6 set wins over clear
        wr_stat(3'b000);
        sec_tick = 1; stat_we = 1; stat_wdata = 3'b000; step();
        sec_tick = 0; stat_we = 0;
        expect_val(0, 8'h02, "R6 set beats clear");

        // R8 interrupt mode
        wr_ctrl(7'h17);
        expect_val(2, 8'd1, "R8 flag2 enabled");
        wr_ctrl(7'h0F);
        expect_val(2, 8'd0, "R8 flag2 not enabled");
        wr_ctrl(7'h17);
        wr_stat(3'b000);
        expect_val(2, 8'd0, "R8 flag cleared");

        // R10 backup
        tick();
        on_backup = 1; step();
        expect_val(3, 8'd1, "R10 hiz on backup");
        expect_val(2, 8'd0, "R10 no drive on backup");
        wr_ctrl(7'h37);
        expect_val(3, 8'd0, "R10 keep-alive hiz");
        expect_val(2, 8'd1, "R10 keep-alive drives");
        on_backup = 0;

        // R7 oscillator stop sets osf
        wr_ctrl(7'h40 | 7'h17);
        expect_val(0, 8'h06, "R7 osf set on stop");

        // R9 waves
        wave_test(2'd3, 1, "R9 rate3");
        wave_test(2'd2, 4, "R9 rate2");
        wave_test(2'd1, 8, "R9 rate1");
        wave_test(2'd0, 32768, "R9 rate0");

        // R7 divider frozen, rate 3 toggles every pulse when running
        rst = 1; step(); rst = 0;
        osc_half_en = 1;
        wr_ctrl(7'h43);        // counts this edge, then stops: div=1
        expect_val(2, 8'd0, "R7 freeze point");
        repeat (3) step();
        expect_val(2, 8'd0, "R7 divider frozen");
        osc_half_en = 0;

        step(); step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule